// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Slave

This block is a two-wire serial-bus slave that lets a host reach a bank of 8-bit registers elsewhere on the chip. It watches the clock and data lines and finds start, repeated start and stop conditions. It compares the 7-bit address that follows each start against a fixed parameter. It acknowledges on the ninth clock of every frame it accepts. It drives the data line only by pulling it low.

Access goes through one 8-bit pointer that keeps its value between transactions. In any write, the first byte after the address loads the pointer. A second byte is stored in the register the pointer selects. A read returns the register at the current pointer, so a read needs no write first when the pointer is already set. A write that sets the pointer can be followed by a repeated start and a read, which fetches one chosen register in a single transaction.

The register bank connects through four plain signals: an address equal to the pointer, write data, a one-cycle write strobe, and read data that the bank returns combinationally for that address.

Top module: `smb_ptr_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` (the pointer) is 0x00.
- R2: Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. An address byte has 7 address bits, MSB first, then a direction bit (0 = write). When the address matches `SLV_ADDR`, SDA is pulled low during the ninth clock. When it does not match, SDA is never pulled low and no byte changes the pointer or writes a register until the next start.
- R3: In a write, the first byte after the address loads the pointer and raises no write strobe. A send-byte transaction (address, one byte, stop) therefore only moves `reg_addr`.
- R4: In a write, the second byte after the address raises `reg_we` for exactly one clock cycle. During that cycle `reg_addr` holds the pointer and `reg_wdata` holds the byte.
- R5: Bytes after the second byte of a write are acknowledged but discarded. No strobe is raised and the pointer does not advance.
- R6: In a read, the slave shifts out the byte on `reg_rdata` for the current pointer, MSB first, one bit per SCL clock.
- R7: A repeated start after a pointer-setting write is accepted as a new address phase. A read that follows returns the newly selected register.
- R8: The pointer keeps its value across stop conditions and is changed only by reset or by the first byte of a write.
- R9: `sda_oe` rises only while SCL is low, and the slave never drives SDA high.
- R10: If the master acknowledges a read byte, the same register is sent again with no pointer increment. If the master does not acknowledge, the slave releases SDA and keeps it released until the next start. A stop always releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as received |
| sda_i | input | 1 | Serial data line as received |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr | output | 8 | Register address (the pointer) |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The hardest case to reach from the ports is the behaviour after a frame that other logic would reject or cut short. This covers bytes that follow a wrong address, data bytes beyond the second, and clocks that follow a master NACK. In each of these the slave must stay silent, or acknowledge and drop the byte. The stimulus reaches them with full-length transactions: a foreign address followed by a data byte, a four-byte write, and a read where the master ACKs once, NACKs, and then keeps clocking with SDA released. A later read shows the pointer was left untouched, and a scoreboard rejects any write strobe it did not expect.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } smb_state_e;

  // Address byte: bits [7:1] carry the device address, bit 0 the direction.
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

  function automatic logic is_read(input logic [7:0] frame);
    return frame[0];
  endfunction

  // Write-byte counter saturates so that trailing bytes are all treated alike.
  function automatic logic [1:0] bump_sat(input logic [1:0] n);
    return (n == 2'd2) ? n : n + 2'd1;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_ptr_core.sv
module smb_ptr_core
  import smb_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2E,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [DW-1:0] reg_rdata,
  output logic          sda_oe,
  output logic [DW-1:0] ptr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  smb_state_e    st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] tx;
  logic [1:0]    nbyte;
  logic          rw;
  logic          mack;

  // Named events for the checks below.
  wire byte_in_done = scl_fall && (cnt == FULL);
  wire bit_sample   = scl_rise && (cnt < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      nbyte     <= '0;
      rw        <= 1'b0;
      mack      <= 1'b1;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_evt) begin
        st     <= S_ADDR;
        cnt    <= '0;
        nbyte  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR, S_RX: begin
            if (bit_sample) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_in_done) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (addr_hit(sh, SLV_ADDR)) begin
                  rw     <= is_read(sh);
                  sda_oe <= 1'b1;
                  st     <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
                nbyte  <= bump_sat(nbyte);
                if (nbyte == 2'd0) begin
                  ptr <= sh;
                end else if (nbyte == 2'd1) begin
                  reg_we    <= 1'b1;
                  reg_wdata <= sh;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= reg_rdata;
                sda_oe <= ~reg_rdata[DW-1];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                tx     <= tx << 1;
                sda_oe <= ~tx[DW-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= sda_s;
            if (scl_fall) begin
              cnt <= '0;
              if (!mack) begin
                tx     <= reg_rdata;
                sda_oe <= ~reg_rdata[DW-1];
                st     <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R9
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R8
  ptr_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave #(
  parameter logic [6:0] SLV_ADDR    = 7'h2E,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smb_ptr_core #(.SLV_ADDR(SLV_ADDR), .DW(8)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .ptr       (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata)
  );

endmodule

// File: tb/smb_ptr_slave_bench.sv
module smb_ptr_slave_bench;

  localparam logic [6:0] DEV = 7'h2E;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;
  logic       sda_line;
  logic [7:0] mem [256];

  int tests = 0;
  int fails = 0;
  int oe_high_rises = 0;
  logic [15:0] exp_wr [$];

  always #10 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  smb_ptr_slave #(.SLV_ADDR(DEV)) u_smb_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every strobe must match the oldest expected write.
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_wr.size() == 0) chk("R3/R5 unexpected write", {reg_addr, reg_wdata}, 0);
      else chk("R4 write", {reg_addr, reg_wdata}, exp_wr.pop_front());
    end
  end

  // R9: the slave may start pulling only while the clock line is low.
  always @(posedge sda_oe) if (scl_m) oe_high_rises++;

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; waitq(); scl_m = 1'b1; waitq();
    seen = sda_line; scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic wr_tx(input logic [7:0] bytes [], input string req);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk({req, " addr ack"}, a, 0);
    foreach (bytes[i]) begin
      send_byte(bytes[i], a); chk({req, " byte ack"}, a, 0);
    end
    bus_stop();
  endtask

  task automatic rd_tx(input logic [7:0] exp, input string req);
    logic a; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a); chk({req, " R2 addr ack"}, a, 0);
    recv_byte(1'b0, d); chk(req, d, exp);
    bus_stop();
  endtask

  initial begin
    logic a; logic s; logic [7:0] d; logic [7:0] e;
    logic [7:0] b1 [];
    int highs;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 oe", sda_oe, 0); chk("R1 we", reg_we, 0); chk("R1 addr", reg_addr, 0);
    rst_n = 1'b1; repeat (4) @(negedge clk);

    // R6 R8: read with no prior write uses the reset pointer
    rd_tx(8'h00 ^ 8'hA5, "R6 read at reset pointer");

    // R3: send byte moves the pointer only
    b1 = new[1]; b1[0] = 8'h10;
    wr_tx(b1, "R3");
    chk("R3 pointer", reg_addr, 8'h10);
    // R8: pointer survived the stop
    rd_tx(8'h10 ^ 8'hA5, "R8 read after stop");

    // R4: write byte
    exp_wr.push_back({8'h20, 8'h5C});
    b1 = new[2]; b1[0] = 8'h20; b1[1] = 8'h5C;
    wr_tx(b1, "R4");
    rd_tx(8'h5C, "R4 readback");

    // R5: trailing bytes acked and dropped
    exp_wr.push_back({8'h30, 8'h11});
    b1 = new[4]; b1[0] = 8'h30; b1[1] = 8'h11; b1[2] = 8'h22; b1[3] = 8'h33;
    wr_tx(b1, "R5");
    chk("R5 no increment", reg_addr, 8'h30);
    chk("R5 scoreboard drained", exp_wr.size(), 0);
    rd_tx(8'h11, "R5 readback");

    // R7: pointer write, repeated start, read
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R7 addr ack", a, 0);
    send_byte(8'h40, a); chk("R7 ptr ack", a, 0);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R7 read addr ack", a, 0);
    recv_byte(1'b0, d); chk("R7 data", d, 8'h40 ^ 8'hA5);
    bus_stop();

    // R2: foreign address is ignored
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); chk("R2 mismatch no ack", a, 1);
    send_byte(8'h77, a); chk("R2 mismatch byte no ack", a, 1);
    bus_stop();
    chk("R2 pointer untouched", reg_addr, 8'h40);

    // R10: master ACK repeats the register, NACK releases the line
    e = 8'h40 ^ 8'hA5;
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R10 addr ack", a, 0);
    recv_byte(1'b1, d); chk("R10 first byte", d, e);
    recv_byte(1'b0, d); chk("R10 repeat byte", d, e);
    highs = 0;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      highs += int'(s);
    end
    chk("R10 released after NACK", highs, 9);
    bus_stop();
    chk("R10 released after stop", sda_oe, 0);

    // R8: reset alone clears the pointer
    rst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R8 pointer after reset", reg_addr, 0);
    rst_n = 1'b1; repeat (3) @(negedge clk);

    chk("R9 oe rose with clock high", oe_high_rises, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule